// File: doc/BRIEF.md
# Swept Line Sensor Frame Aligner and Nibble Unpacker

This block sits behind the digital output of a swept-finger line sensor. The sensor delivers one byte per pixel clock and never marks a frame boundary on a separate wire. Instead, every frame ends with an extra column whose first two bytes hold a fixed pattern. The block counts byte positions on its own and checks for that pattern at the place it expects it. It declares lock after repeated confirmation and drops back to searching when the pattern goes missing.

While locked, each image byte is split into its two 4-bit pixels. The pixel from the upper nibble belongs to the odd sensor row and the pixel from the lower nibble to the even row. Both pixels leave on one cycle, tagged with their column and row, and a start-of-frame flag marks the first pair of the first column. The last two bytes of the marker column carry a status nibble, a temperature nibble and two further nibbles. These are never emitted as pixels. They are latched and announced with a one-cycle flag once per locked frame.

Top module: `sweep_frame_sync`

## Requirements
- R1: For each image byte, the upper nibble (bit 7 is its MSB) leaves on `pix_odd_o` and the lower nibble (bit 3 is its MSB) on `pix_even_o`. For byte k of a column (k = 0..3), `pix_row_o` is 2k, the zero-based row of the odd pixel; the even pixel lies on row 2k+1.
- R2: A frame is NUM_COLS image columns of 4 bytes, followed by one 4-byte marker column. `pix_col_o` runs from 0 to NUM_COLS-1 and advances every 4 accepted bytes.
- R3: `pix_sof_o` is high exactly with the pixel pair from byte 0 of column 0, and low on every other cycle.
- R4: No pixel pair is emitted unless the block was locked when the byte arrived. Marker-column bytes are never emitted as pixels.
- R5: A marker byte matches when bits 7:5 are 111 and bits 3:0 are 0000; bit 4 is ignored. In the search state, two consecutive matching bytes fix the frame position. Lock is declared when the pair is found again at the expected place one frame later (LOCK_HITS = 2 sightings in total). `locked_o` rises on the cycle after the second byte of the confirming pair.
- R6: While locked, a frame whose marker pair is absent at the expected place counts as a miss, and pixels keep flowing at the counted positions. A matching pair clears the miss count. MISS_LIMIT = 2 consecutive misses drop lock and restart the search.
- R7: While locked, marker byte 3 is latched (upper nibble to `meta_stat_o`, lower to `meta_temp_o`) and marker byte 4 is latched (upper to `meta_aux_odd_o`, lower to `meta_aux_even_o`). `meta_valid_o` pulses for one cycle after marker byte 4.
- R8: A cycle with `byte_valid_i` low advances no counter or state and produces no pixel or metadata pulse.
- R9: All outputs are registered: the result of a byte accepted on a clock edge appears right after that edge.
- R10: After reset, the block is in the search state with `locked_o`, `pix_valid_o`, `pix_sof_o` and `meta_valid_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Raw sensor byte |
| byte_valid_i | input | 1 | Byte strobe |
| pix_valid_o | output | 1 | Pixel pair valid |
| pix_odd_o | output | 4 | Odd-row pixel (upper nibble) |
| pix_even_o | output | 4 | Even-row pixel (lower nibble) |
| pix_row_o | output | $clog2(BYTES_PER_COL)+1 | Zero-based row of the odd pixel |
| pix_col_o | output | $clog2(NUM_COLS+1) | Zero-based image column |
| pix_sof_o | output | 1 | First pair of a frame |
| locked_o | output | 1 | Frame lock held |
| meta_valid_o | output | 1 | Metadata nibbles updated |
| meta_stat_o | output | 4 | Status nibble from marker byte 3 |
| meta_temp_o | output | 4 | Temperature nibble from marker byte 3 |
| meta_aux_odd_o | output | 4 | Upper nibble of marker byte 4 |
| meta_aux_even_o | output | 4 | Lower nibble of marker byte 4 |

## Verification
The bench builds the block with NUM_COLS = 6, which gives a 28-byte frame, and keeps the default lock and miss thresholds of 2. The short frame allows dozens of frames in a few thousand cycles. That covers acquisition from an arbitrary byte offset, single-miss tolerance, loss of lock after two bad markers, and recovery after a one-byte slip of the stream, all mixed with random gaps in the byte strobe. The full-size frame differs only in the column counter range, which the short frame already wraps many times.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

  // marker byte: 111x_0000
  function automatic logic marker_byte(input logic [7:0] b);
    return (b[7:5] == 3'b111) && (b[3:0] == 4'h0);
  endfunction
endpackage

// File: rtl/sfs_marker_det.sv
module sfs_marker_det
  import sfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       pair_hit_o
);
  logic prev_q;
  logic cur;

  assign cur        = marker_byte(byte_i);
  assign pair_hit_o = valid_i && cur && prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= 1'b0;
    else if (valid_i) prev_q <= cur;
  end
endmodule

// File: rtl/sfs_pos_ctr.sv
module sfs_pos_ctr #(
  parameter int unsigned NUM_COLS      = 280,
  parameter int unsigned BYTES_PER_COL = 4,
  parameter int unsigned COL_W         = 9,
  parameter int unsigned SUB_W         = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  output logic [COL_W-1:0] col_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam logic [COL_W-1:0] MARK_COL = COL_W'(NUM_COLS);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(BYTES_PER_COL - 1);
  // after the second marker byte the next byte is marker byte 3
  localparam logic [SUB_W-1:0] LOAD_SUB = SUB_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o <= '0;
      sub_o <= '0;
    end else if (load_i) begin
      col_o <= MARK_COL;
      sub_o <= LOAD_SUB;
    end else if (step_i) begin
      if (sub_o == LAST_SUB) begin
        sub_o <= '0;
        col_o <= (col_o == MARK_COL) ? '0 : col_o + COL_W'(1);
      end else begin
        sub_o <= sub_o + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfs_lock_fsm.sv
module sfs_lock_fsm
  import sfs_pkg::*;
#(
  parameter int unsigned LOCK_HITS  = 2,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        pair_hit_i,
  input  logic        at_check_i,
  output sync_state_e state_o,
  output logic        load_o
);
  localparam int unsigned HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);

  sync_state_e       st_q, st_d;
  logic [HIT_W-1:0]  hit_q, hit_d, hit_inc;
  logic [MISS_W-1:0] miss_q, miss_d, miss_inc;
  logic              chk;

  assign hit_inc  = hit_q + HIT_W'(1);
  assign miss_inc = miss_q + MISS_W'(1);
  assign chk      = valid_i && at_check_i;
  assign load_o   = valid_i && (st_q == ST_SEARCH) && pair_hit_i;
  assign state_o  = st_q;

  always_comb begin
    st_d   = st_q;
    hit_d  = hit_q;
    miss_d = miss_q;
    unique case (st_q)
      ST_SEARCH: if (load_o) begin
        hit_d  = HIT_W'(1);
        miss_d = '0;
        st_d   = (LOCK_HITS <= 1) ? ST_LOCKED : ST_VERIFY;
      end
      ST_VERIFY: if (chk) begin
        if (pair_hit_i) begin
          hit_d = hit_inc;
          if (hit_inc >= HIT_W'(LOCK_HITS)) st_d = ST_LOCKED;
        end else begin
          st_d = ST_SEARCH;
        end
      end
      ST_LOCKED: if (chk) begin
        if (pair_hit_i) begin
          miss_d = '0;
        end else begin
          miss_d = miss_inc;
          if (miss_inc >= MISS_W'(MISS_LIMIT)) st_d = ST_SEARCH;
        end
      end
      default: st_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/sfs_unpack.sv
module sfs_unpack #(
  parameter int unsigned NUM_COLS = 280,
  parameter int unsigned COL_W    = 9,
  parameter int unsigned SUB_W    = 2,
  parameter int unsigned ROW_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             locked_i,
  output logic             pix_valid_o,
  output logic [3:0]       pix_odd_o,
  output logic [3:0]       pix_even_o,
  output logic [ROW_W-1:0] pix_row_o,
  output logic [COL_W-1:0] pix_col_o,
  output logic             pix_sof_o,
  output logic             meta_valid_o,
  output logic [3:0]       meta_stat_o,
  output logic [3:0]       meta_temp_o,
  output logic [3:0]       meta_aux_odd_o,
  output logic [3:0]       meta_aux_even_o
);
  logic take, in_mark, img, db3, db4;

  assign take    = valid_i && locked_i;
  assign in_mark = (col_i == COL_W'(NUM_COLS));
  assign img     = take && !in_mark;
  assign db3     = take && in_mark && (sub_i == SUB_W'(2));
  assign db4     = take && in_mark && (sub_i == SUB_W'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o     <= 1'b0;
      pix_odd_o       <= '0;
      pix_even_o      <= '0;
      pix_row_o       <= '0;
      pix_col_o       <= '0;
      pix_sof_o       <= 1'b0;
      meta_valid_o    <= 1'b0;
      meta_stat_o     <= '0;
      meta_temp_o     <= '0;
      meta_aux_odd_o  <= '0;
      meta_aux_even_o <= '0;
    end else begin
      pix_valid_o  <= img;
      pix_sof_o    <= img && (col_i == '0) && (sub_i == '0);
      meta_valid_o <= db4;
      if (img) begin
        pix_odd_o  <= byte_i[7:4];
        pix_even_o <= byte_i[3:0];
        pix_row_o  <= {sub_i, 1'b0};
        pix_col_o  <= col_i;
      end
      if (db3) begin
        meta_stat_o <= byte_i[7:4];
        meta_temp_o <= byte_i[3:0];
      end
      if (db4) begin
        meta_aux_odd_o  <= byte_i[7:4];
        meta_aux_even_o <= byte_i[3:0];
      end
    end
  end
endmodule

// File: rtl/sweep_frame_sync.sv
module sweep_frame_sync
  import sfs_pkg::*;
#(
  parameter int unsigned NUM_COLS      = 280,
  parameter int unsigned BYTES_PER_COL = 4,
  parameter int unsigned LOCK_HITS     = 2,
  parameter int unsigned MISS_LIMIT    = 2,
  localparam int unsigned COL_W = $clog2(NUM_COLS + 1),
  localparam int unsigned SUB_W = $clog2(BYTES_PER_COL),
  localparam int unsigned ROW_W = SUB_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             pix_valid_o,
  output logic [3:0]       pix_odd_o,
  output logic [3:0]       pix_even_o,
  output logic [ROW_W-1:0] pix_row_o,
  output logic [COL_W-1:0] pix_col_o,
  output logic             pix_sof_o,
  output logic             locked_o,
  output logic             meta_valid_o,
  output logic [3:0]       meta_stat_o,
  output logic [3:0]       meta_temp_o,
  output logic [3:0]       meta_aux_odd_o,
  output logic [3:0]       meta_aux_even_o
);
  sync_state_e      state;
  logic             pair_hit, load, at_check;
  logic [COL_W-1:0] col;
  logic [SUB_W-1:0] sub;

  // second marker byte position is where a pair can be confirmed
  assign at_check = (col == COL_W'(NUM_COLS)) && (sub == SUB_W'(1));
  assign locked_o = (state == ST_LOCKED);

  sfs_marker_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .valid_i    (byte_valid_i),
    .pair_hit_o (pair_hit)
  );

  sfs_pos_ctr #(
    .NUM_COLS      (NUM_COLS),
    .BYTES_PER_COL (BYTES_PER_COL),
    .COL_W         (COL_W),
    .SUB_W         (SUB_W)
  ) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (byte_valid_i),
    .load_i (load),
    .col_o  (col),
    .sub_o  (sub)
  );

  sfs_lock_fsm #(
    .LOCK_HITS  (LOCK_HITS),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (byte_valid_i),
    .pair_hit_i (pair_hit),
    .at_check_i (at_check),
    .state_o    (state),
    .load_o     (load)
  );

  sfs_unpack #(
    .NUM_COLS (NUM_COLS),
    .COL_W    (COL_W),
    .SUB_W    (SUB_W),
    .ROW_W    (ROW_W)
  ) u_unp (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .valid_i         (byte_valid_i),
    .byte_i          (byte_i),
    .col_i           (col),
    .sub_i           (sub),
    .locked_i        (locked_o),
    .pix_valid_o     (pix_valid_o),
    .pix_odd_o       (pix_odd_o),
    .pix_even_o      (pix_even_o),
    .pix_row_o       (pix_row_o),
    .pix_col_o       (pix_col_o),
    .pix_sof_o       (pix_sof_o),
    .meta_valid_o    (meta_valid_o),
    .meta_stat_o     (meta_stat_o),
    .meta_temp_o     (meta_temp_o),
    .meta_aux_odd_o  (meta_aux_odd_o),
    .meta_aux_even_o (meta_aux_even_o)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int unsigned NUM_COLS      = 280,
  parameter int unsigned BYTES_PER_COL = 4,
  localparam int unsigned COL_W = $clog2(NUM_COLS + 1),
  localparam int unsigned SUB_W = $clog2(BYTES_PER_COL),
  localparam int unsigned ROW_W = SUB_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       byte_i,
  input logic             byte_valid_i,
  input logic             pix_valid_o,
  input logic [ROW_W-1:0] pix_row_o,
  input logic [COL_W-1:0] pix_col_o,
  input logic             pix_sof_o,
  input logic             locked_o,
  input logic             meta_valid_o
);
  a_r1_row_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_row_o[0] == 1'b0));

  a_r2_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_col_o < COL_W'(NUM_COLS)));

  a_r3_sof_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sof_o |-> (pix_valid_o && (pix_col_o == '0) && (pix_row_o == '0)));

  a_r4_pix_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(locked_o));

  a_r5_lock_after_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(byte_valid_i && (byte_i[7:5] == 3'b111) && (byte_i[3:0] == 4'h0)));

  a_r6_drop_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(byte_valid_i));

  a_r7_meta_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_o |-> ($past(locked_o) && !pix_valid_o));

  a_r8_gap_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> (!pix_valid_o && !meta_valid_o));
endmodule

bind sweep_frame_sync sfs_checker #(
  .NUM_COLS      (NUM_COLS),
  .BYTES_PER_COL (BYTES_PER_COL)
) u_sfs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_i       (byte_i),
  .byte_valid_i (byte_valid_i),
  .pix_valid_o  (pix_valid_o),
  .pix_row_o    (pix_row_o),
  .pix_col_o    (pix_col_o),
  .pix_sof_o    (pix_sof_o),
  .locked_o     (locked_o),
  .meta_valid_o (meta_valid_o)
);

// File: tb/sweep_frame_sync_tb_top.sv
`timescale 1ns/1ps
module sweep_frame_sync_tb_top;
  localparam int NC    = 6;
  localparam int BPC   = 4;
  localparam int COL_W = $clog2(NC + 1);
  localparam int ROW_W = $clog2(BPC) + 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       byte_i = '0;
  logic             byte_valid_i = 1'b0;
  logic             pix_valid_o, pix_sof_o, locked_o, meta_valid_o;
  logic [3:0]       pix_odd_o, pix_even_o;
  logic [ROW_W-1:0] pix_row_o;
  logic [COL_W-1:0] pix_col_o;
  logic [3:0]       meta_stat_o, meta_temp_o, meta_aux_odd_o, meta_aux_even_o;

  always #2.5 clk_i = ~clk_i;

  sweep_frame_sync #(.NUM_COLS(NC), .BYTES_PER_COL(BPC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .pix_valid_o(pix_valid_o), .pix_odd_o(pix_odd_o), .pix_even_o(pix_even_o),
    .pix_row_o(pix_row_o), .pix_col_o(pix_col_o), .pix_sof_o(pix_sof_o),
    .locked_o(locked_o), .meta_valid_o(meta_valid_o), .meta_stat_o(meta_stat_o),
    .meta_temp_o(meta_temp_o), .meta_aux_odd_o(meta_aux_odd_o),
    .meta_aux_even_o(meta_aux_even_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  int m_state = 0;  // 0 search, 1 verify, 2 locked
  int m_hits = 0, m_miss = 0, m_col = 0, m_sub = 0;
  bit m_prev = 1'b0;
  // expected outputs for the edge after the last driven byte (R9)
  bit e_pv = 0, e_sof = 0, e_lock = 0, e_mv = 0, e_gap = 0;
  int e_odd = 0, e_even = 0, e_row = 0, e_col = 0;
  int e_stat = 0, e_temp = 0, e_ao = 0, e_ae = 0;

  function automatic logic [7:0] img_byte();
    return {4'($urandom_range(15, 0)), 4'($urandom_range(15, 1))};
  endfunction

  function automatic logic [7:0] mark_byte();
    return {3'b111, 1'($urandom_range(1, 0)), 4'h0};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_lock ? "R5" : "R6", "locked_o", int'(locked_o), int'(e_lock));
    chk(e_gap ? "R8" : "R4", "pix_valid_o", int'(pix_valid_o), int'(e_pv));
    chk("R3", "pix_sof_o", int'(pix_sof_o), int'(e_sof));
    if (e_pv) begin
      chk("R1", "pix_odd_o", int'(pix_odd_o), e_odd);
      chk("R1", "pix_even_o", int'(pix_even_o), e_even);
      chk("R1", "pix_row_o", int'(pix_row_o), e_row);
      chk("R2", "pix_col_o", int'(pix_col_o), e_col);
    end
    chk(e_gap ? "R8" : "R7", "meta_valid_o", int'(meta_valid_o), int'(e_mv));
    if (e_mv) begin
      chk("R7", "meta_stat_o", int'(meta_stat_o), e_stat);
      chk("R7", "meta_temp_o", int'(meta_temp_o), e_temp);
      chk("R7", "meta_aux_odd_o", int'(meta_aux_odd_o), e_ao);
      chk("R7", "meta_aux_even_o", int'(meta_aux_even_o), e_ae);
    end
  endtask

  task automatic model_step(input logic [7:0] b, input bit v);
    bit mk, pair, at_chk;
    e_pv = 0; e_sof = 0; e_mv = 0; e_gap = !v;
    if (!v) return;
    mk     = (b[7:5] == 3'b111) && (b[3:0] == 4'h0);
    pair   = mk && m_prev;
    at_chk = (m_state != 0) && (m_col == NC) && (m_sub == 1);
    if (m_state == 2 && m_col != NC) begin
      e_pv = 1; e_odd = int'(b[7:4]); e_even = int'(b[3:0]);
      e_row = 2 * m_sub; e_col = m_col; e_sof = (m_col == 0) && (m_sub == 0);
    end
    if (m_state == 2 && m_col == NC && m_sub == 2) begin
      e_stat = int'(b[7:4]); e_temp = int'(b[3:0]);
    end
    if (m_state == 2 && m_col == NC && m_sub == 3) begin
      e_ao = int'(b[7:4]); e_ae = int'(b[3:0]); e_mv = 1;
    end
    if (m_state == 0 && pair) begin
      m_col = NC; m_sub = 2;
    end else if (m_sub == BPC - 1) begin
      m_sub = 0; m_col = (m_col == NC) ? 0 : m_col + 1;
    end else begin
      m_sub++;
    end
    case (m_state)
      0: if (pair) begin m_hits = 1; m_miss = 0; m_state = 1; end
      1: if (at_chk) begin
           if (pair) begin m_hits++; if (m_hits >= 2) m_state = 2; end
           else m_state = 0;
         end
      default: if (at_chk) begin
           if (pair) m_miss = 0;
           else begin m_miss++; if (m_miss >= 2) m_state = 0; end
         end
    endcase
    m_prev = mk;
    e_lock = (m_state == 2);
  endtask

  task automatic send(input logic [7:0] b, input bit v);
    @(negedge clk_i);
    compare_all();
    byte_i = b;
    byte_valid_i = v;
    model_step(b, v);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap_pct);
    while (int'($urandom_range(99, 0)) < gap_pct) send(8'($urandom()), 1'b0);
    send(b, 1'b1);
  endtask

  task automatic send_frame(input bit bad1, input bit bad2, input int gap_pct);
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < BPC; s++) send_byte(img_byte(), gap_pct);
    send_byte(bad1 ? img_byte() : mark_byte(), gap_pct);
    send_byte(bad2 ? img_byte() : mark_byte(), gap_pct);
    send_byte(img_byte(), gap_pct);
    send_byte(img_byte(), gap_pct);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: reset state
    chk("R10", "locked_o at reset", int'(locked_o), 0);
    chk("R10", "pix_valid_o at reset", int'(pix_valid_o), 0);
    chk("R10", "meta_valid_o at reset", int'(meta_valid_o), 0);
    chk("R10", "pix_sof_o at reset", int'(pix_sof_o), 0);
    // R5: acquire from an arbitrary offset, no gaps
    for (int i = 0; i < 11; i++) send_byte(img_byte(), 0);
    send_frame(0, 0, 0);
    send_frame(0, 0, 0);
    send_frame(0, 0, 0);
    chk("R5", "locked after confirmed marker", int'(e_lock), 1);
    // R8: gaps in the strobe
    for (int f = 0; f < 4; f++) send_frame(0, 0, 30);
    // R6: single miss keeps lock
    send_frame(0, 1, 10);
    send_frame(0, 0, 10);
    send_frame(1, 0, 10);
    send_frame(0, 0, 10);
    // R6: two consecutive misses drop lock, then relock
    send_frame(1, 0, 0);
    send_frame(0, 1, 0);
    send_frame(0, 0, 0);
    send_frame(0, 0, 0);
    send_frame(0, 0, 0);
    // stream slips by one byte
    send_byte(img_byte(), 0);
    for (int f = 0; f < 5; f++) send_frame(0, 0, 15);
    // random mix
    for (int f = 0; f < 40; f++) begin
      bit b1, b2;
      b1 = ($urandom_range(9, 0) == 0);
      b2 = ($urandom_range(9, 0) == 0);
      send_frame(b1, b2, 20);
      if ($urandom_range(19, 0) == 0) send_byte(img_byte(), 0);
    end
    send(8'h00, 1'b0);
    send(8'h00, 1'b0);
    finish_run();
  end
endmodule